// File: doc/BRIEF.md
# PWM Duty Cycle Measurement Unit

This block measures the duty cycle of pulse-width-modulated lines on behalf of two independent measurement channels, A and B. Four candidate PWM lines enter the block. Each channel has a four-bit assignment mask that names the lines belonging to it. When a mask names more than one line, a fixed priority picks the single line that is timed. The block times the selected line with the system clock. The period is the number of cycles from one rising edge to the next. The high time is the number of cycles from a rising edge to the following falling edge.

A free-running publish counter fires once every `TICK_CYCLES` clock cycles. The default models a 10 ms interval at 200 MHz, and a smaller value shortens it for simulation. On each publish event, both channels write their result registers in the same cycle and a one-cycle strobe marks the update. A channel reports the duty cycle of the last complete period it measured, as an unsigned fraction of 256. A channel with no assigned line, or with no complete period in the window, reports 0 and raises its invalid bit.

Top module: `pwm_duty_meter`

## Requirements
- R1: Channels A and B are measured independently. Each has its own duty output and invalid bit, and activity on lines not selected by a channel has no effect on that channel's result.
- R2: Mask bit 0 selects line 0, bit 1 line 1, bit 2 line 2 and bit 3 line 3. When several bits are set, the lowest set bit wins.
- R3: The period is measured from rising edge to rising edge and the high time from a rising edge to the next falling edge. The published duty is floor(high * 256 / period).
- R4: Results are published on the clock edge that ends every `TICK_CYCLES`-cycle window. The first publish occurs on the `TICK_CYCLES`-th rising edge after reset is released. Between publishes the duty and invalid outputs hold their values.
- R5: `updateStrobe` is high for exactly the one cycle that follows each publish edge, which is the cycle in which both channels' new values first appear.
- R6: A channel whose mask is zero at the publish edge reports duty 0 with its invalid bit set to 1.
- R7: A channel with no period completed since the previous publish edge reports duty 0 with its invalid bit set to 1. This includes a line held constant low or constant high.
- R8: When several periods complete within a window, the published value uses the most recent one that completed before the publish edge.
- R9: During reset and until the first publish, the duty outputs are 0, the invalid bits are 1 and the strobe is 0.
- R10: A rising edge that arrives more than 2^CNT_W − 1 cycles after the previous rising edge does not complete a period. Its interval is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 4 | Candidate PWM lines; bit i is line i |
| assignA | input | 4 | Line assignment mask for channel A |
| assignB | input | 4 | Line assignment mask for channel B |
| dutyA | output | 8 | Channel A duty, high*256/period |
| dutyB | output | 8 | Channel B duty, high*256/period |
| invalidA | output | 1 | Channel A result not valid |
| invalidB | output | 1 | Channel B result not valid |
| updateStrobe | output | 1 | One-cycle pulse after each publish |

## Verification
The bench builds the block with `TICK_CYCLES` = 400 and `CNT_W` = 10. With these values a publish window is short enough for many windows to fit into a run. Periods from 30 to 900 cycles can complete within a few windows. A 1100-cycle period exceeds the 1023-cycle counter range, so the discard rule of R10 can be exercised in a few thousand cycles. The lines run at distinct periods, and the masks are changed between windows, so each channel's value depends only on its own selected line.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

  typedef struct packed {
    logic publish;   // end of window: write results
    logic restart;   // begin a new window
  } ctrl_t;

  // lowest set mask bit wins; returns level of that line (0 if none)
  function automatic logic pickLine(input logic [3:0] mask, input logic [3:0] lines);
    logic lvl;
    lvl = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      if (mask[i]) lvl = lines[i];
    end
    return lvl;
  endfunction

endpackage

// File: rtl/duty_ctrl.sv
module duty_ctrl
  import pwm_duty_pkg::*;
#(
  parameter int TICK_CYCLES = 2_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  output ctrl_t ctrl,
  output logic  strobe
);
  localparam int TICK_W = $clog2(TICK_CYCLES);

  logic [TICK_W-1:0] tickCnt;
  logic              lastCycle;

  assign lastCycle = (tickCnt == TICK_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
    end else if (lastCycle) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.publish = lastCycle;
    ctrl.restart = lastCycle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= lastCycle;
  end

endmodule

// File: rtl/duty_path.sv
module duty_path
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W  = 22,
  parameter int DUTY_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_t                 ctrl,
  input  logic [3:0]            pwmIn,
  input  logic [1:0][3:0]       maskArr,
  output logic [1:0][DUTY_W-1:0] dutyArr,
  output logic [1:0]            invalidArr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int QW = CNT_W + DUTY_W;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic             selLvl, prevLvl, rise, fall, complete;
    logic [CNT_W-1:0] cnt, pendHigh, capHigh, capPer;
    logic             haveRise, pendValid, winFlag;
    logic [QW-1:0]    numer, denom, quot;

    assign selLvl   = pickLine(maskArr[ch], pwmIn);
    assign rise     = selLvl & ~prevLvl;
    assign fall     = ~selLvl & prevLvl;
    assign complete = rise & haveRise & pendValid;

    // edge history and elapsed-cycle counter since last rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevLvl  <= 1'b0;
        cnt      <= '0;
        haveRise <= 1'b0;
      end else begin
        prevLvl <= selLvl;
        if (rise) begin
          cnt      <= CNT_W'(1);
          haveRise <= 1'b1;
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          else                haveRise <= 1'b0;   // interval too long: drop
        end
      end
    end

    // high-time capture and period completion
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendValid <= 1'b0;
        pendHigh  <= '0;
        capHigh   <= '0;
        capPer    <= '0;
      end else begin
        if (rise) begin
          pendValid <= 1'b0;
        end else if (fall && haveRise && !pendValid) begin
          pendValid <= 1'b1;
          pendHigh  <= cnt;
        end
        if (complete) begin
          capHigh <= pendHigh;
          capPer  <= cnt;
        end
      end
    end

    // window tracking: any completion since the last publish
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            winFlag <= 1'b0;
      else if (ctrl.restart) winFlag <= complete;
      else if (complete)     winFlag <= 1'b1;
    end

    assign numer = {capHigh, DUTY_W'(0)};
    assign denom = (capPer == '0) ? QW'(1) : QW'(capPer);
    assign quot  = numer / denom;

    // published result registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dutyArr[ch]    <= '0;
        invalidArr[ch] <= 1'b1;
      end else if (ctrl.publish) begin
        if (winFlag && (maskArr[ch] != 4'b0)) begin
          dutyArr[ch]    <= quot[DUTY_W-1:0];
          invalidArr[ch] <= 1'b0;
        end else begin
          dutyArr[ch]    <= '0;
          invalidArr[ch] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_duty_pkg::*;
#(
  parameter int TICK_CYCLES = 2_000_000,
  parameter int CNT_W       = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pwmIn,
  input  logic [3:0] assignA,
  input  logic [3:0] assignB,
  output logic [7:0] dutyA,
  output logic [7:0] dutyB,
  output logic       invalidA,
  output logic       invalidB,
  output logic       updateStrobe
);
  ctrl_t           ctrl;
  logic [1:0][3:0] maskArr;
  logic [1:0][7:0] dutyArr;
  logic [1:0]      invalidArr;

  assign maskArr[0] = assignA;
  assign maskArr[1] = assignB;

  duty_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .strobe (updateStrobe)
  );

  duty_path #(.CNT_W(CNT_W), .DUTY_W(8)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .pwmIn      (pwmIn),
    .maskArr    (maskArr),
    .dutyArr    (dutyArr),
    .invalidArr (invalidArr)
  );

  assign dutyA    = dutyArr[0];
  assign dutyB    = dutyArr[1];
  assign invalidA = invalidArr[0];
  assign invalidB = invalidArr[1];

endmodule

// File: rtl/pwm_duty_meter_chk.sv
module pwm_duty_meter_chk #(
  parameter int TICK_CYCLES = 2_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] assignA,
  input logic [3:0] assignB,
  input logic [7:0] dutyA,
  input logic [7:0] dutyB,
  input logic       invalidA,
  input logic       invalidB,
  input logic       updateStrobe
);
  localparam int CW = $clog2(TICK_CYCLES) + 1;

  logic [CW-1:0] chkCnt;
  logic          wrapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkCnt  <= '0;
      wrapped <= 1'b0;
    end else if (chkCnt == CW'(TICK_CYCLES - 1)) begin
      chkCnt  <= '0;
      wrapped <= 1'b1;
    end else begin
      chkCnt <= chkCnt + 1'b1;
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |=> !updateStrobe);

  // R4
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |-> (chkCnt == '0) && wrapped);

  // R4
  strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chkCnt == '0) && wrapped) |-> updateStrobe);

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updateStrobe |-> $stable(dutyA) && $stable(invalidA));

  // R4
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updateStrobe |-> $stable(dutyB) && $stable(invalidB));

  // R6
  unassigned_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updateStrobe && $past(assignA) == 4'b0) |-> invalidA && dutyA == 8'd0);

  // R6
  unassigned_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updateStrobe && $past(assignB) == 4'b0) |-> invalidB && dutyB == 8'd0);

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidA |-> dutyA == 8'd0) and (invalidB |-> dutyB == 8'd0));

endmodule

bind pwm_duty_meter pwm_duty_meter_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .assignA      (assignA),
  .assignB      (assignB),
  .dutyA        (dutyA),
  .dutyB        (dutyB),
  .invalidA     (invalidA),
  .invalidB     (invalidB),
  .updateStrobe (updateStrobe)
);

// File: tb/pwm_duty_meter_bench.sv
`timescale 1ns/1ps
module pwm_duty_meter_bench;
  localparam int TICK  = 400;
  localparam int CW    = 10;
  localparam int MAXC  = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pwmIn;
  logic [3:0] assignA = 4'b0, assignB = 4'b0;
  logic [7:0] dutyA, dutyB;
  logic       invalidA, invalidB, updateStrobe;

  always #2.5 clk = ~clk;

  pwm_duty_meter #(.TICK_CYCLES(TICK), .CNT_W(CW)) u_pwm_duty_meter (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .assignA(assignA), .assignB(assignB),
    .dutyA(dutyA), .dutyB(dutyB), .invalidA(invalidA), .invalidB(invalidB),
    .updateStrobe(updateStrobe));

  int total = 0, bad = 0;
  string tag = "R9";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---- PWM generators: per line period, high time, enable, idle level
  int  genP[4], genH[4], genC[4];
  bit  genOn[4], genIdle[4];
  always_comb begin
    for (int i = 0; i < 4; i++)
      pwmIn[i] = genOn[i] ? (genC[i] < genH[i]) : genIdle[i];
  end
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) genC[i] <= (genC[i] + 1 >= genP[i]) ? 0 : genC[i] + 1;
    end
  end

  // ---- reference model: timestamps of edges per channel
  int  n = 0, tc = 0;
  int  lastRise[2], pendH[2], capH[2], capP[2];
  bit  prevL[2], flag[2];
  int  eDuty[2];
  bit  eInv[2], eStb;

  function automatic int lowSel(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit tickNow;
      tickNow = (tc == TICK - 1);
      tc = tickNow ? 0 : tc + 1;
      for (int ch = 0; ch < 2; ch++) begin
        logic [3:0] m;
        int sel;
        bit s, rise, fall, vPrev, comp;
        m = (ch == 0) ? assignA : assignB;
        sel = lowSel(m);
        s = (sel >= 0) ? pwmIn[sel] : 1'b0;
        rise = s && !prevL[ch];
        fall = !s && prevL[ch];
        prevL[ch] = s;
        vPrev = (lastRise[ch] >= 0) && (n - lastRise[ch] <= MAXC);
        comp = rise && vPrev && (pendH[ch] >= 0);
        if (tickNow) begin
          if (flag[ch] && m != 0) begin
            eDuty[ch] = (capH[ch] * 256) / capP[ch];
            eInv[ch] = 1'b0;
          end else begin
            eDuty[ch] = 0;
            eInv[ch] = 1'b1;
          end
        end
        if (comp) begin
          capH[ch] = pendH[ch];
          capP[ch] = n - lastRise[ch];
        end
        flag[ch] = tickNow ? comp : (flag[ch] | comp);
        if (rise) begin
          lastRise[ch] = n;
          pendH[ch] = -1;
        end else if (fall && vPrev && pendH[ch] < 0) begin
          pendH[ch] = n - lastRise[ch];
        end
      end
      eStb = tickNow;
      n++;
    end
  end

  // ---- comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(updateStrobe == eStb, "R5", updateStrobe, eStb);
      if (eStb) begin
        chk(dutyA == eDuty[0], {tag, " chA duty"}, dutyA, eDuty[0]);
        chk(invalidA == eInv[0], {tag, " chA invalid"}, invalidA, eInv[0]);
        chk(dutyB == eDuty[1], {tag, " chB duty"}, dutyB, eDuty[1]);
        chk(invalidB == eInv[1], {tag, " chB invalid"}, invalidB, eInv[1]);
      end else begin
        chk(dutyA == eDuty[0] && dutyB == eDuty[1], "R4 hold",
            {dutyA, dutyB}, {eDuty[0][7:0], eDuty[1][7:0]});
      end
    end
  end

  task automatic setLine(input int i, input int p, input int h);
    genP[i] = p; genH[i] = h; genOn[i] = 1'b1; genC[i] = 0;
  endtask

  task automatic windows(input int k);
    repeat (k * TICK) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      lastRise[c] = -1; pendH[c] = -1; capH[c] = 0; capP[c] = 1;
      prevL[c] = 0; flag[c] = 0; eDuty[c] = 0; eInv[c] = 1;
    end
    eStb = 0;
    setLine(0, 40, 10);
    setLine(1, 50, 35);
    setLine(2, 64, 16);
    setLine(3, 30, 27);
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(dutyA == 0 && dutyB == 0, "R9 duty", {dutyA, dutyB}, 0);
    chk(invalidA && invalidB && !updateStrobe, "R9 flags",
        {invalidA, invalidB, updateStrobe}, 3'b110);
    rst_n = 1'b1;
    // R1/R3: independent channels on distinct lines
    tag = "R1 R3"; assignA = 4'b0001; assignB = 4'b0010;
    windows(3);
    // R2: priority among several assigned lines
    tag = "R2"; assignA = 4'b0110; assignB = 4'b1100;
    windows(2);
    tag = "R2"; assignA = 4'b1111; assignB = 4'b1000;
    windows(2);
    // R6: empty mask
    tag = "R6"; assignA = 4'b0000; assignB = 4'b1000;
    windows(2);
    // R8: line 3 changes period mid-window
    tag = "R8"; assignA = 4'b1000; assignB = 4'b0100;
    repeat (150) @(negedge clk);
    setLine(3, 25, 5);
    windows(2);
    // R7: selected lines stop toggling (low on 0, high on 2)
    tag = "R7"; assignA = 4'b0001; assignB = 4'b0100;
    genOn[0] = 1'b0; genIdle[0] = 1'b0;
    genOn[2] = 1'b0; genIdle[2] = 1'b1;
    windows(3);
    // R10: 1100-cycle period exceeds counter range; 900 does not
    tag = "R10"; assignA = 4'b0001; assignB = 4'b0010;
    setLine(0, 1100, 50);
    setLine(1, 900, 300);
    windows(12);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule